// File: doc/BRIEF.md
# Program Status Word Unit

This block keeps the processor's live status word and one saved copy of it, both 32 bits wide. Software-visible writes arrive as field-masked updates. The data comes either from a register operand or from an 8-bit constant rotated right by an even amount. Each write targets either the live word or the saved word. Reads return the selected word in full on a combinational bus.

Alongside the explicit accesses, a data-processing unit can push new condition flags into the live word. It can also request a restore, in which the saved word replaces the live word in one step; this is how exception returns complete. Privilege controls what may change. In user mode the control byte of the live word is frozen. The mode field always keeps bit 4 set. The execution-state bit can be changed only through the saved word.

Top module: `stw_unit`

## Requirements
- R1: While reset is held, the live word is `{24'h0, 2'b11, 1'b0, RST_MODE}` (0x000000D3 with the default supervisor mode 0x13) and the saved word is 0x00000010. `cur_mode` equals live word bits 4:0 at all times.
- R2: Byte enables are per field: `fld_flag` enables bits 31:24 and `fld_ctrl` enables bits 7:0. On the live word, a flag-byte write updates only bits 31:28, and it does so in every mode.
- R3: In any mode other than user (0x10), a control-byte write to the live word loads bits 7, 6 and 3:0 from the source. It forces bit 4 to 1 and leaves bit 5 unchanged.
- R4: In user mode, a control-byte write to the live word is ignored. Live word bits 7:0 do not change while the mode is user.
- R5: A write to the saved word changes only enabled bits within mask 0xF00000EF, which includes the state bit 5. The write takes effect only when the current mode is neither user (0x10) nor system (0x1F). Otherwise the saved word is unchanged.
- R6: With `wr_imm_sel` = 1, the source is `imm_field[7:0]` rotated right by twice `imm_field[11:8]`. With `wr_imm_sel` = 0, the source is `reg_opnd`.
- R7: `rd_data` shows the saved word when `rd_saved_sel` = 1 and the live word otherwise, in the same cycle.
- R8: A restore request in a mode other than user or system copies the whole saved word into the live word on the next edge. In user or system mode the request has no effect.
- R9: `flag_we` loads `flag_nzcv` into live word bits 31:28, with N in bit 31, Z in 30, C in 29 and V in 28. Bits 27:8 of the live word change only through a restore.
- R10: The live word takes one update per cycle, in priority order: an effective restore first, then an explicit live-word write, then a flag update. A saved-word write in the same cycle as a restore updates the saved word, and the restore uses the old saved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Field-masked write request |
| wr_tgt_saved | input | 1 | Write target: 1 = saved word, 0 = live word |
| wr_imm_sel | input | 1 | Source select: 1 = rotated immediate, 0 = register operand |
| fld_ctrl | input | 1 | Enable for control byte (bits 7:0) |
| fld_flag | input | 1 | Enable for flag byte (bits 31:24) |
| reg_opnd | input | 32 | Register operand source |
| imm_field | input | 12 | Rotate amount (11:8) and constant (7:0) |
| flag_we | input | 1 | Flag update strobe from data-processing unit |
| flag_nzcv | input | 4 | New N, Z, C, V flags |
| restore_req | input | 1 | Copy saved word into live word |
| rd_saved_sel | input | 1 | Read select: 1 = saved word, 0 = live word |
| rd_data | output | 32 | Selected word |
| cur_word | output | 32 | Live status word |
| sav_word | output | 32 | Saved status word |
| cur_mode | output | 5 | Current mode field |

## Verification
The bench builds the unit with the default reset mode of supervisor (0x13). Starting privileged lets the sequence write control and saved fields first and then step through interrupt mode, system mode after a restore, and finally user mode, where the privilege gates are probed. The immediate widths stay at 8-bit constant and 4-bit rotate, so zero rotation, small rotation and wrap-around rotation are all within reach.

// File: rtl/stw_pkg.sv
// Shared constants for the status word unit.
// Assumes a 32-bit word with flags in the top nibble and mode in bits 4:0.
package stw_pkg;
    localparam int WORD_W  = 32;
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int MODE_W  = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    localparam logic [WORD_W-1:0] LIVE_FLAG_BITS = 32'hF000_0000;
    localparam logic [WORD_W-1:0] LIVE_CTRL_BITS = 32'h0000_00CF;
    localparam logic [WORD_W-1:0] SAVE_OK_BITS   = 32'hF000_00EF;
    localparam logic [WORD_W-1:0] MODE_HI_BIT    = 32'h0000_0010;
    localparam logic [WORD_W-1:0] SAVE_RST_VAL   = 32'h0000_0010;

    // True for modes that own a saved word.
    function automatic logic mode_has_saved(input logic [MODE_W-1:0] m);
        return (m != MODE_USR) && (m != MODE_SYS);
    endfunction
endpackage

// File: rtl/stw_imm_rot.sv
// Expands an immediate field into a full word: constant rotated right by
// twice the rotate field. Purely combinational.
module stw_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W+ROT_W-1:0] field,
    output logic [DATA_W-1:0]      value
);
    localparam int AMT_W = ROT_W + 1;

    logic [DATA_W-1:0] ext;
    logic [AMT_W-1:0]  amt;

    // Zero-extend constant and double the rotate count.
    always_comb begin
        ext   = DATA_W'(field[IMM_W-1:0]);
        amt   = {field[IMM_W+ROT_W-1:IMM_W], 1'b0};
        value = (ext >> amt) | (ext << (DATA_W - int'(amt)));
    end
endmodule

// File: rtl/stw_byte_mask.sv
// Turns per-field enables into a bit mask: one enable for the top byte,
// one for the bottom byte. Middle bytes never enabled.
module stw_byte_mask #(
    parameter int DATA_W = 32
) (
    input  logic              en_lo,
    input  logic              en_hi,
    output logic [DATA_W-1:0] mask
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        if (b == 0) begin : g_lo
            assign mask[8*b +: 8] = {8{en_lo}};
        end else if (b == NBYTES - 1) begin : g_hi
            assign mask[8*b +: 8] = {8{en_hi}};
        end else begin : g_mid
            assign mask[8*b +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/stw_unit.sv
// Live and saved program status words with privilege-gated masked writes,
// flag updates and restore. Assumes one update source wins per cycle.
module stw_unit
    import stw_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_tgt_saved,
    input  logic                 wr_imm_sel,
    input  logic                 fld_ctrl,
    input  logic                 fld_flag,
    input  logic [WORD_W-1:0]    reg_opnd,
    input  logic [IMM_W+ROT_W-1:0] imm_field,
    input  logic                 flag_we,
    input  logic [3:0]           flag_nzcv,
    input  logic                 restore_req,
    input  logic                 rd_saved_sel,
    output logic [WORD_W-1:0]    rd_data,
    output logic [WORD_W-1:0]    cur_word,
    output logic [WORD_W-1:0]    sav_word,
    output logic [MODE_W-1:0]    cur_mode
);
    localparam logic [WORD_W-1:0] LIVE_RST_VAL =
        {{(WORD_W-8){1'b0}}, 2'b11, 1'b0, RST_MODE};

    logic [WORD_W-1:0] live_q, save_q;
    logic [WORD_W-1:0] imm_val, src, byte_en;
    logic [WORD_W-1:0] live_m, save_m, live_wr_val, save_wr_val;
    logic              priv, has_sav, live_wr, save_wr, do_rest;

    stw_imm_rot #(.DATA_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .field (imm_field),
        .value (imm_val)
    );

    stw_byte_mask #(.DATA_W(WORD_W)) u_mask (
        .en_lo (fld_ctrl),
        .en_hi (fld_flag),
        .mask  (byte_en)
    );

    // Decode privilege, pick source, build the masked write values.
    always_comb begin
        priv    = live_q[MODE_W-1:0] != MODE_USR;
        has_sav = mode_has_saved(live_q[MODE_W-1:0]);
        src     = wr_imm_sel ? imm_val : reg_opnd;
        live_wr = wr_en && !wr_tgt_saved;
        save_wr = wr_en && wr_tgt_saved && has_sav;
        do_rest = restore_req && has_sav;
        live_m  = byte_en & (LIVE_FLAG_BITS | (priv ? LIVE_CTRL_BITS : '0));
        save_m  = byte_en & SAVE_OK_BITS;
        live_wr_val = (live_q & ~live_m) | (src & live_m);
        if ((live_m & LIVE_CTRL_BITS) != '0) begin
            live_wr_val = live_wr_val | MODE_HI_BIT;
        end
        save_wr_val = (save_q & ~save_m) | (src & save_m);
    end

    // Live word: restore beats explicit write beats flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= LIVE_RST_VAL;
        end else if (do_rest) begin
            live_q <= save_q;
        end else if (live_wr) begin
            live_q <= live_wr_val;
        end else if (flag_we) begin
            live_q <= {flag_nzcv, live_q[WORD_W-5:0]};
        end
    end

    // Saved word: masked write only in modes that own one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q <= SAVE_RST_VAL;
        end else if (save_wr) begin
            save_q <= save_wr_val;
        end
    end

    // Output drive.
    always_comb begin
        cur_word = live_q;
        sav_word = save_q;
        cur_mode = live_q[MODE_W-1:0];
        rd_data  = rd_saved_sel ? save_q : live_q;
    end
endmodule

// File: rtl/stw_unit_chk.sv
// Temporal checks on the status word unit, attached by bind.
module stw_unit_chk
    import stw_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_tgt_saved,
    input logic                 flag_we,
    input logic [3:0]           flag_nzcv,
    input logic                 restore_req,
    input logic [WORD_W-1:0]    cur_word,
    input logic [WORD_W-1:0]    sav_word,
    input logic [MODE_W-1:0]    cur_mode
);
    // R4
    user_ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR) |=> $stable(cur_word[7:0]));

    // R5
    saved_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_tgt_saved && cur_mode != MODE_USR && cur_mode != MODE_SYS)
        |=> $stable(sav_word));

    // R8
    restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && cur_mode != MODE_USR && cur_mode != MODE_SYS)
        |=> cur_word == $past(sav_word));

    // R9
    mid_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_req |=> $stable(cur_word[27:8]));

    // R9
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !restore_req && !(wr_en && !wr_tgt_saved))
        |=> cur_word[31:28] == $past(flag_nzcv));
endmodule

bind stw_unit stw_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_tgt_saved (wr_tgt_saved),
    .flag_we      (flag_we),
    .flag_nzcv    (flag_nzcv),
    .restore_req  (restore_req),
    .cur_word     (cur_word),
    .sav_word     (sav_word),
    .cur_mode     (cur_mode)
);

// File: tb/stw_unit_test.sv
module stw_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_tgt_saved = 0, wr_imm_sel = 0;
    logic        fld_ctrl = 0, fld_flag = 0;
    logic [31:0] reg_opnd = '0;
    logic [11:0] imm_field = '0;
    logic        flag_we = 0;
    logic [3:0]  flag_nzcv = '0;
    logic        restore_req = 0, rd_saved_sel = 0;
    logic [31:0] rd_data, cur_word, sav_word;
    logic [4:0]  cur_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] cm, sm;

    stw_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt_saved(wr_tgt_saved),
        .wr_imm_sel(wr_imm_sel), .fld_ctrl(fld_ctrl), .fld_flag(fld_flag),
        .reg_opnd(reg_opnd), .imm_field(imm_field), .flag_we(flag_we),
        .flag_nzcv(flag_nzcv), .restore_req(restore_req),
        .rd_saved_sel(rd_saved_sel), .rd_data(rd_data), .cur_word(cur_word),
        .sav_word(sav_word), .cur_mode(cur_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Rotate one bit at a time, twice per rotate step.
    function automatic logic [31:0] model_rot(input logic [11:0] f);
        logic [31:0] v = {24'h0, f[7:0]};
        for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
        return v;
    endfunction

    // Reference model, updated bit by bit on each clock.
    always @(posedge clk) begin : model
        logic [31:0] src, ncm, nsm;
        logic        sav_ok, en;
        if (!rst_n) begin
            cm = 32'h0000_00D3;
            sm = 32'h0000_0010;
        end else begin
            src    = wr_imm_sel ? model_rot(imm_field) : reg_opnd;
            sav_ok = (cm[4:0] != 5'h10) && (cm[4:0] != 5'h1F);
            ncm = cm;
            nsm = sm;
            if (wr_en && wr_tgt_saved && sav_ok) begin
                for (int b = 0; b < 32; b++) begin
                    en = (b >= 24) ? fld_flag : (b < 8) ? fld_ctrl : 1'b0;
                    if (en && (b >= 28 || (b >= 5 && b <= 7) || b <= 3))
                        nsm[b] = src[b];
                end
            end
            if (restore_req && sav_ok) begin
                ncm = sm;
            end else if (wr_en && !wr_tgt_saved) begin
                if (fld_flag) ncm[31:28] = src[31:28];
                if (fld_ctrl && cm[4:0] != 5'h10) begin
                    ncm[7:6] = src[7:6];
                    ncm[3:0] = src[3:0];
                    ncm[4]   = 1'b1;
                end
            end else if (flag_we) begin
                ncm[31:28] = flag_nzcv;
            end
            cm = ncm;
            sm = nsm;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock and compare every output with the model.
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " cur"}, cur_word, cm);
        chk({tag, " sav"}, sav_word, sm);
        chk({tag, " mode"}, {27'h0, cur_mode}, {27'h0, cm[4:0]});
        chk({tag, " rd"}, rd_data, rd_saved_sel ? sm : cm);
    endtask

    task automatic idle();
        wr_en = 0; wr_tgt_saved = 0; wr_imm_sel = 0; fld_ctrl = 0; fld_flag = 0;
        flag_we = 0; restore_req = 0;
    endtask

    task automatic wr(input bit tgt_sav, input bit imm, input bit c, input bit f,
                      input logic [31:0] op, input logic [11:0] immf);
        idle();
        wr_en = 1; wr_tgt_saved = tgt_sav; wr_imm_sel = imm;
        fld_ctrl = c; fld_flag = f; reg_opnd = op; imm_field = immf;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step("R1 reset");
        chk("R1 cur literal", cur_word, 32'h0000_00D3);
        chk("R1 sav literal", sav_word, 32'h0000_0010);
        rst_n = 1;

        wr(0, 0, 0, 1, 32'hA5FF_FF00, '0);      step("R2 live flag byte");
        chk("R2 literal", cur_word, 32'hA000_00D3);
        wr(0, 0, 1, 0, 32'h0000_00F1, '0);      step("R3 live ctrl");
        chk("R3 literal", cur_word, 32'hA000_00D1);
        wr(0, 0, 1, 1, 32'h3FFF_FF02, '0);      step("R3 to irq mode");
        chk("R3 mode literal", {27'h0, cur_mode}, 32'h12);
        wr(1, 0, 1, 1, 32'hFFFF_FFFF, '0);      step("R5 saved full");
        chk("R5 literal", sav_word, 32'hF000_00FF);
        wr(1, 1, 0, 1, '0, 12'h4AB);            step("R6 imm rot8 saved");
        chk("R6 literal", sav_word, 32'hA000_00FF);
        wr(0, 1, 0, 1, '0, 12'h103);            step("R6 imm rot2 live");
        wr(0, 1, 1, 0, '0, 12'h0C5);            step("R6 imm rot0 live");
        wr(1, 1, 1, 0, '0, 12'hF2C);            step("R6 imm wrap saved");
        idle(); rd_saved_sel = 1;               step("R7 read saved");
        rd_saved_sel = 0;                       step("R7 read live");
        idle(); flag_we = 1; flag_nzcv = 4'h5;  step("R9 flag update");
        wr(0, 0, 0, 1, 32'h9000_0000, '0);
        flag_we = 1; flag_nzcv = 4'h6;          step("R10 write beats flags");
        wr(1, 0, 1, 1, 32'hF000_00FF, '0);      step("R5 saved prep");
        wr(0, 0, 1, 1, 32'h0000_0013, '0);
        restore_req = 1; flag_we = 1;           step("R10 restore wins");
        chk("R8 restore literal", cur_word, 32'hF000_00FF);
        idle(); restore_req = 1;                step("R8 restore ignored in system");
        wr(1, 0, 1, 1, 32'h0000_0000, '0);      step("R5 saved ignored in system");
        wr(0, 0, 1, 0, 32'h0000_0010, '0);      step("R3 to user");
        chk("R3 state bit kept", cur_word, 32'hF000_0030);
        wr(0, 0, 1, 1, 32'h5000_00D3, '0);      step("R4 ctrl ignored in user");
        chk("R4 literal", cur_word, 32'h5000_0030);
        idle(); restore_req = 1; flag_we = 1; flag_nzcv = 4'hA;
        step("R8 restore ignored in user");
        idle(); rd_saved_sel = 1;               step("R7 read saved user");
        finish_run();
    end
endmodule